// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is a synchronous slave for a two-wire serial bus (SMBus/I2C timing). It oversamples SCL and SDA in the system clock domain, finds start and stop conditions, and answers to one configurable 7-bit device address. Register access goes through an 8-bit pointer. The first data byte of every write transaction loads the pointer. An optional second byte goes to the register that the pointer names.

Each storage register has two pointer values. One is used to write it and a different one is used to read it. A read transaction returns one byte, taken from whatever register the pointer currently selects, and leaves the pointer unchanged. Writing any value to one reserved pointer value does not store anything. Instead it fires a single-cycle trigger pulse that a neighbouring conversion engine can use.

The block drives the bus only through a pull-down enable. The pad, the pull-up and the wired-AND are outside it. The system clock must run at least eight times faster than SCL.

Top module: `smb_ptr_slave`

## Requirements
- R1: While reset is held and directly after it, `sda_pull`, `wr_stb` and `trig_pulse` are low, and all storage registers read 0x00.
- R2: The slave pulls SDA low in the ninth clock of the address byte only when the seven address bits (sent MSB first, followed by R/W) equal `dev_addr`. On a mismatch it acknowledges nothing until the next start.
- R3: In a write transaction (R/W = 0), the first data byte is acknowledged and stored in the pointer without producing any strobe. A later read transaction uses this pointer.
- R4: A second write data byte with pointer 0x08+i (i below N_REGS) is acknowledged, pulses `wr_stb` for one cycle with `wr_idx` = i and `wr_data` = the byte, and stores the byte so that pointer 0x00+i reads it back.
- R5: A read transaction (R/W = 1) shifts out, MSB first, the register that pointer 0x00+i selects, or 0xFF for any pointer outside the read range. Repeated reads without a pointer write return the same register.
- R6: A second write byte aimed at a read-only or unmapped pointer is acknowledged but changes no register and produces neither strobe.
- R7: A second write byte with pointer 0x0F, of any value, produces exactly one `trig_pulse` of one cycle and no `wr_stb`.
- R8: In the ninth clock of a read byte the slave releases SDA, and it keeps SDA released until the next start or stop, whatever the master answers.
- R9: A third data byte in one write transaction is not acknowledged and has no effect.
- R10: A start condition received in the middle of a byte abandons that byte and begins a new address reception.
- R11: A stop condition at any point releases SDA and returns the slave to idle. The next transaction is served normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line (wired-AND level) |
| dev_addr | input | 7 | Device address this slave answers to |
| sda_pull | output | 1 | High to pull SDA low |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_idx | output | IDX_W (2) | Index of the register written |
| wr_data | output | 8 | Byte written |
| trig_pulse | output | 1 | One-cycle conversion request |

## Verification
Several properties are checked on every cycle. A stop always leaves the slave idle with SDA released, and a start always restarts address reception. The address acknowledge is issued only after a matching address. The skip state never drives the bus. Write strobes and trigger pulses last one cycle and never occur together, and register contents change only under a strobe. Other behaviour can only be shown by the bench's bus scenarios: the data values seen at the ports, persistence of the pointer across reads, the 0xFF response for unmapped pointers, and refusal of a third byte. The bench also shows that a write to a read-only pointer leaves the register unchanged.

// File: rtl/smb_ptr_pkg.sv
package smb_ptr_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    // Bus-level engine states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_WR,
        ST_ACK_WR,
        ST_RD,
        ST_SKIP
    } bus_state_e;

    // Decoded line events, one cycle each
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/smb_bus_sampler.sv
module smb_bus_sampler
    import smb_ptr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_s;
        logic [SYNC_STAGES-1:0] sda_s;
        logic                   scl_p;
        logic                   sda_p;
    } samp_t;

    samp_t samp_q, samp_d;
    logic  scl_now;
    logic  sda_now;

    assign scl_now = samp_q.scl_s[SYNC_STAGES-1];
    assign sda_now = samp_q.sda_s[SYNC_STAGES-1];

    always_comb begin
        samp_d       = samp_q;
        samp_d.scl_s = {samp_q.scl_s[SYNC_STAGES-2:0], scl_in};
        samp_d.sda_s = {samp_q.sda_s[SYNC_STAGES-2:0], sda_in};
        samp_d.scl_p = scl_now;
        samp_d.sda_p = sda_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) samp_q <= '1;   // idle bus reads high
        else        samp_q <= samp_d;
    end

    always_comb begin
        evt.scl_rise = scl_now & ~samp_q.scl_p;
        evt.scl_fall = ~scl_now & samp_q.scl_p;
        evt.start    = scl_now & samp_q.scl_p & samp_q.sda_p & ~sda_now;
        evt.stop     = scl_now & samp_q.scl_p & ~samp_q.sda_p & sda_now;
        evt.sda      = sda_now;
    end

endmodule

// File: rtl/smb_frame_ctrl.sv
module smb_frame_ctrl
    import smb_ptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] ptr,
    output logic              dwr,
    output logic [BYTE_W-1:0] dbyte
);

    typedef struct packed {
        bus_state_e           st;
        logic [BYTE_W-1:0]    sh;
        logic [BIT_CNT_W-1:0] cnt;
        logic                 full;
        logic                 rw;
        logic [1:0]           nbytes;
        logic [BYTE_W-1:0]    ptr;
        logic                 pull;
        logic                 dwr;
        logic [BYTE_W-1:0]    dbyte;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.dwr = 1'b0;
        if (evt.start) begin
            ctl_d.st   = ST_ADDR;
            ctl_d.cnt  = '0;
            ctl_d.full = 1'b0;
            ctl_d.pull = 1'b0;
        end else if (evt.stop) begin
            ctl_d.st   = ST_IDLE;
            ctl_d.full = 1'b0;
            ctl_d.pull = 1'b0;
        end else begin
            unique case (ctl_q.st)
                ST_ADDR, ST_WR: begin
                    if (evt.scl_rise) begin
                        ctl_d.sh  = {ctl_q.sh[BYTE_W-2:0], evt.sda};
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                        if (ctl_q.cnt == LAST_BIT) ctl_d.full = 1'b1;
                    end else if (evt.scl_fall && ctl_q.full) begin
                        ctl_d.full = 1'b0;
                        if (ctl_q.st == ST_ADDR) begin
                            if (ctl_q.sh[BYTE_W-1:1] == dev_addr) begin
                                ctl_d.st   = ST_ACK_ADDR;
                                ctl_d.pull = 1'b1;
                                ctl_d.rw   = ctl_q.sh[0];
                            end else begin
                                ctl_d.st = ST_SKIP;
                            end
                        end else if (ctl_q.nbytes == 2'd0) begin
                            ctl_d.ptr    = ctl_q.sh;
                            ctl_d.nbytes = 2'd1;
                            ctl_d.pull   = 1'b1;
                            ctl_d.st     = ST_ACK_WR;
                        end else if (ctl_q.nbytes == 2'd1) begin
                            ctl_d.dwr    = 1'b1;
                            ctl_d.dbyte  = ctl_q.sh;
                            ctl_d.nbytes = 2'd2;
                            ctl_d.pull   = 1'b1;
                            ctl_d.st     = ST_ACK_WR;
                        end else begin
                            ctl_d.st = ST_SKIP;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (evt.scl_fall) begin
                        ctl_d.cnt = '0;
                        if (ctl_q.rw) begin
                            ctl_d.st   = ST_RD;
                            ctl_d.sh   = rd_data;
                            ctl_d.pull = ~rd_data[BYTE_W-1];
                        end else begin
                            ctl_d.st     = ST_WR;
                            ctl_d.pull   = 1'b0;
                            ctl_d.nbytes = 2'd0;
                        end
                    end
                end
                ST_ACK_WR: begin
                    if (evt.scl_fall) begin
                        ctl_d.pull = 1'b0;
                        ctl_d.cnt  = '0;
                        ctl_d.st   = ST_WR;
                    end
                end
                ST_RD: begin
                    if (evt.scl_fall) begin
                        if (ctl_q.cnt == LAST_BIT) begin
                            ctl_d.st   = ST_SKIP;
                            ctl_d.pull = 1'b0;
                        end else begin
                            ctl_d.sh   = {ctl_q.sh[BYTE_W-2:0], 1'b0};
                            ctl_d.pull = ~ctl_q.sh[BYTE_W-2];
                            ctl_d.cnt  = ctl_q.cnt + 1'b1;
                        end
                    end
                end
                default: ctl_d.pull = 1'b0;   // idle and skip never drive
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_pull = ctl_q.pull;
    assign ptr      = ctl_q.ptr;
    assign dwr      = ctl_q.dwr;
    assign dbyte    = ctl_q.dbyte;

    // R2: address acknowledge only after a matching address byte
    a_r2_ack_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ACK_ADDR && $past(ctl_q.st) == ST_ADDR)
            |-> (ctl_q.sh[BYTE_W-1:1] == dev_addr && sda_pull));

    // R10: a start always restarts address reception, bus released
    a_r10_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> (ctl_q.st == ST_ADDR && !sda_pull));

    // R11: a stop always returns to idle with SDA released
    a_r11_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> (ctl_q.st == ST_IDLE && !sda_pull));

    // R8: skipping slave never drives the bus
    a_r8_skip_released: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SKIP || ctl_q.st == ST_IDLE) |-> !sda_pull);

    // R9: at most one data store request per byte boundary
    a_r9_dwr_single: assert property (@(posedge clk) disable iff (!rst_n)
        dwr |=> !dwr);

endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file
    import smb_ptr_pkg::*;
#(
    parameter int              N_REGS    = 4,
    parameter logic [BYTE_W-1:0] RD_BASE   = 8'h00,
    parameter logic [BYTE_W-1:0] WR_BASE   = 8'h08,
    parameter logic [BYTE_W-1:0] TRIG_ADDR = 8'h0F,
    localparam int             IDX_W     = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] ptr,
    input  logic              dwr,
    input  logic [BYTE_W-1:0] dbyte,
    output logic [BYTE_W-1:0] rd_data,
    output logic              wr_stb,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              trig_pulse
);

    logic [N_REGS-1:0] wr_hit;
    logic [N_REGS-1:0] rd_hit;

    for (genvar g = 0; g < N_REGS; g++) begin : g_decode
        assign wr_hit[g] = (ptr == BYTE_W'(WR_BASE + g));
        assign rd_hit[g] = (ptr == BYTE_W'(RD_BASE + g));
    end

    typedef struct packed {
        logic [N_REGS-1:0][BYTE_W-1:0] regs;
        logic                          stb;
        logic [IDX_W-1:0]              idx;
        logic [BYTE_W-1:0]             data;
        logic                          trig;
    } rf_t;

    rf_t rf_q, rf_d;

    always_comb begin
        rf_d      = rf_q;
        rf_d.stb  = 1'b0;
        rf_d.trig = 1'b0;
        if (dwr) begin
            if (ptr == TRIG_ADDR) begin
                rf_d.trig = 1'b1;
            end else begin
                for (int i = 0; i < N_REGS; i++) begin
                    if (wr_hit[i]) begin
                        rf_d.regs[i] = dbyte;
                        rf_d.stb     = 1'b1;
                        rf_d.idx     = IDX_W'(i);
                        rf_d.data    = dbyte;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    always_comb begin
        rd_data = '1;   // unmapped read pointer
        for (int i = 0; i < N_REGS; i++) begin
            if (rd_hit[i]) rd_data = rf_q.regs[i];
        end
    end

    assign wr_stb     = rf_q.stb;
    assign wr_idx     = rf_q.idx;
    assign wr_data    = rf_q.data;
    assign trig_pulse = rf_q.trig;

    // R4: write strobe lasts a single cycle
    a_r4_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R7: trigger never coincides with a register store
    a_r7_trig_alone: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> !wr_stb);

    // R6: register contents change only together with a strobe
    a_r6_store_needs_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_q.regs != $past(rf_q.regs)) |-> wr_stb);

endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
    import smb_ptr_pkg::*;
#(
    parameter int                N_REGS      = 4,
    parameter logic [BYTE_W-1:0] RD_BASE     = 8'h00,
    parameter logic [BYTE_W-1:0] WR_BASE     = 8'h08,
    parameter logic [BYTE_W-1:0] TRIG_ADDR   = 8'h0F,
    parameter int                SYNC_STAGES = 2,
    localparam int               IDX_W       = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              sda_pull,
    output logic              wr_stb,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              trig_pulse
);

    bus_evt_t          evt;
    logic [BYTE_W-1:0] ptr;
    logic [BYTE_W-1:0] rd_data;
    logic              dwr;
    logic [BYTE_W-1:0] dbyte;

    smb_bus_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    smb_frame_ctrl u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .dev_addr (dev_addr),
        .rd_data  (rd_data),
        .sda_pull (sda_pull),
        .ptr      (ptr),
        .dwr      (dwr),
        .dbyte    (dbyte)
    );

    smb_reg_file #(
        .N_REGS    (N_REGS),
        .RD_BASE   (RD_BASE),
        .WR_BASE   (WR_BASE),
        .TRIG_ADDR (TRIG_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr        (ptr),
        .dwr        (dwr),
        .dbyte      (dbyte),
        .rd_data    (rd_data),
        .wr_stb     (wr_stb),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .trig_pulse (trig_pulse)
    );

endmodule

// File: tb/smb_ptr_slave_tb.sv
module smb_ptr_slave_tb;

    localparam logic [6:0] DEV = 7'h4C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull;
    logic       wr_stb;
    logic [1:0] wr_idx;
    logic [7:0] wr_data;
    logic       trig_pulse;
    wire        sda_line = sda_m & ~sda_pull;

    always #2 clk = ~clk;   // 250 MHz

    smb_ptr_slave u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_m),
        .sda_in     (sda_line),
        .dev_addr   (DEV),
        .sda_pull   (sda_pull),
        .wr_stb     (wr_stb),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .trig_pulse (trig_pulse)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit is_trig;
        int idx;
        int data;
    } exp_t;
    exp_t expq[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clk_bit(input bit b, output bit r);
        sda_m = b;
        wait_clk(10);
        scl_m = 1'b1;
        wait_clk(10);
        r = sda_line;
        wait_clk(10);
        scl_m = 1'b0;
        wait_clk(10);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wait_clk(10);
        scl_m = 1'b1;
        wait_clk(10);
        sda_m = 1'b0;
        wait_clk(10);
        scl_m = 1'b0;
        wait_clk(10);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wait_clk(10);
        scl_m = 1'b1;
        wait_clk(10);
        sda_m = 1'b1;
        wait_clk(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit r;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
        clk_bit(1'b1, r);
        acked = !r;
    endtask

    task automatic recv_byte(output logic [7:0] v, output bit line9);
        bit r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, r);
            v[i] = r;
        end
        clk_bit(1'b1, r);   // master answers no acknowledge
        line9 = r;
    endtask

    // Expected events follow from the pointer map in R4 and R7
    task automatic push_expect(input logic [7:0] p, input logic [7:0] data);
        exp_t e;
        if (p >= 8'h08 && p <= 8'h0B) begin
            e.is_trig = 1'b0; e.idx = int'(p) - 8; e.data = int'(data);
            expq.push_back(e);
        end else if (p == 8'h0F) begin
            e.is_trig = 1'b1; e.idx = 0; e.data = 0;
            expq.push_back(e);
        end
    endtask

    task automatic write_txn(input logic [7:0] p, input bit has_data,
                             input logic [7:0] data, input string req);
        bit ak;
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        check(ak, "R2", int'(ak), 1);
        send_byte(p, ak);
        check(ak, "R3", int'(ak), 1);
        if (has_data) begin
            push_expect(p, data);
            send_byte(data, ak);
            check(ak, req, int'(ak), 1);
        end
        bus_stop();
    endtask

    task automatic read_cur(input logic [7:0] exp, input string req);
        bit ak;
        bit l9;
        logic [7:0] v;
        bus_start();
        send_byte({DEV, 1'b1}, ak);
        check(ak, "R2", int'(ak), 1);
        recv_byte(v, l9);
        check(v == exp, req, int'(v), int'(exp));
        check(l9 == 1'b1, "R8", int'(l9), 1);
        bus_stop();
    endtask

    task automatic read_at(input logic [7:0] p, input logic [7:0] exp, input string req);
        write_txn(p, 1'b0, 8'h00, req);
        read_cur(exp, req);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (wr_stb || trig_pulse)) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R6 unexpected strobe actual=stb%0d/trig%0d expected=none",
                         wr_stb, trig_pulse);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (e.is_trig) begin
                    if (!(trig_pulse && !wr_stb)) begin
                        errors++;
                        $display("FAIL R7 actual=stb%0d/trig%0d expected=trig only",
                                 wr_stb, trig_pulse);
                    end
                end else if (!(wr_stb && !trig_pulse && int'(wr_idx) == e.idx
                               && int'(wr_data) == e.data)) begin
                    errors++;
                    $display("FAIL R4 actual=idx%0d/0x%0h expected=idx%0d/0x%0h",
                             wr_idx, wr_data, e.idx, e.data);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit ak;
        bit r;
        wait_clk(5);
        // R1: reset state
        check(!sda_pull && !wr_stb && !trig_pulse, "R1", int'({sda_pull, wr_stb, trig_pulse}), 0);
        rst_n = 1'b1;
        wait_clk(5);
        check(!sda_pull && !wr_stb && !trig_pulse, "R1", int'({sda_pull, wr_stb, trig_pulse}), 0);
        read_at(8'h00, 8'h00, "R1");

        // R4: store into register 1 via write pointer 0x09
        write_txn(8'h09, 1'b1, 8'hA5, "R4");
        // R3 / R5: pointer load then repeated reads
        read_at(8'h01, 8'hA5, "R5");
        read_cur(8'hA5, "R5");

        // R2: foreign address is ignored entirely
        bus_start();
        send_byte({7'h4D, 1'b0}, ak);
        check(!ak, "R2", int'(ak), 0);
        send_byte(8'h08, ak);
        check(!ak, "R2", int'(ak), 0);
        send_byte(8'h99, ak);
        check(!ak, "R2", int'(ak), 0);
        bus_stop();
        read_cur(8'hA5, "R3");

        // R6: write to read-only pointer 0x02 has no effect
        write_txn(8'h02, 1'b1, 8'h33, "R6");
        read_at(8'h02, 8'h00, "R6");

        // R7: trigger pointer
        write_txn(8'h0F, 1'b1, 8'h77, "R7");
        read_at(8'h01, 8'hA5, "R7");

        // R5: unmapped and write-only pointers read 0xFF
        read_at(8'h05, 8'hFF, "R5");
        read_at(8'h09, 8'hFF, "R5");

        // R9: third data byte refused
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        check(ak, "R2", int'(ak), 1);
        send_byte(8'h0A, ak);
        check(ak, "R3", int'(ak), 1);
        push_expect(8'h0A, 8'h11);
        send_byte(8'h11, ak);
        check(ak, "R4", int'(ak), 1);
        send_byte(8'h22, ak);
        check(!ak, "R9", int'(ak), 0);
        bus_stop();
        read_at(8'h02, 8'h11, "R9");

        // R10: repeated start after half an address byte
        bus_start();
        for (int i = 7; i >= 4; i--) clk_bit(ak, r);
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        check(ak, "R10", int'(ak), 1);
        send_byte(8'h0B, ak);
        check(ak, "R10", int'(ak), 1);
        push_expect(8'h0B, 8'h5C);
        send_byte(8'h5C, ak);
        check(ak, "R10", int'(ak), 1);
        bus_stop();
        read_at(8'h03, 8'h5C, "R10");

        // R11: stop inside a data byte
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        check(ak, "R2", int'(ak), 1);
        clk_bit(1'b0, r);
        clk_bit(1'b0, r);
        clk_bit(1'b1, r);
        bus_stop();
        wait_clk(5);
        check(!sda_pull, "R11", int'(sda_pull), 0);
        read_at(8'h01, 8'hA5, "R11");

        wait_clk(20);
        check(expq.size() == 0, "R4", expq.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule